// File: doc/BRIEF.md
# Cache-Line Burst Memory Emulator

This block is a small on-chip memory that takes the place of external DRAM behind a processor with separate instruction and data caches. Both caches fill 16-byte lines. The data cache also sends write-through stores of one Dword at a time. A line fill begins at the Dword the cache asked for and continues in interleaved order. Each Dword the block returns comes with three things: the Dword's position on a cache-RAM write address, a set of write-control pulses for the requesting cache, and a completion strobe on the final Dword.

Stores do not go straight to the memory array. They collect in two line-wide buffers, and a buffer empties into memory during a cycle that has no read beat and no incoming store. A write-enable output warns the data cache when both buffers are occupied. A store to the same line as the previous store is still taken while write-enable is low, because it merges into the buffer that already holds that line. Addresses are 28 bits wide. Only the lowest 16 KB is implemented.

Top module: `lf_linefill_mem`

## Requirements
- R1: A cacheable read request produces exactly four beats on four consecutive cycles. On each beat the requesting port's write-control bit 1 is high. That port's done output is high on the fourth beat only. After the fourth beat, both control outputs return to zero unless another request is waiting.
- R2: The first beat carries the Dword selected by request address bits [3:2]. Write-control bit 2 is high on the first beat only.
- R3: With start index s, beat k carries Dword s XOR k. This gives the orders 0,1,2,3 / 1,0,3,2 / 2,3,0,1 / 3,2,1,0.
- R4: During every beat, waddr (address bits [11:2]) holds request address bits [11:4] in its upper eight bits and the index of the Dword now delivered in its low two bits.
- R5: A read request with its non-cacheable input high produces one beat. On that beat write-control is 3'b111, meaning bit 0 (non-cacheable) is high, and done is high.
- R6: If both ports request in the same cycle, the data port is served first. The instruction request is held and its first beat follows the data port's last beat in the next cycle. Only one port's write-control is non-zero at a time.
- R7: A store word is 36 bits wide. Bits [31:0] are data and bit 32+i enables byte i. Only the enabled bytes of the addressed Dword change in memory.
- R8: There are two store buffers, each holding one line. wr_en goes low once both buffers hold lines. A buffer drains only in a cycle with no read beat and no incoming store. wr_en is high again in the cycle after a drain.
- R9: A store to the same line as the previous accepted store is merged and kept even while wr_en is low. A store to any other line is discarded while wr_en is low.
- R10: Reads of addresses at or above 16 KB return zero data, still with the normal beat count and control pulses. Stores to such addresses do not change memory.
- R11: After reset, both write-control outputs and both done outputs are zero, rd_data is zero and wr_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dc_rd | input | 1 | Data-port line read request, one-cycle strobe |
| dc_wr | input | 1 | Data-port store strobe |
| dc_nc | input | 1 | Data-port read is non-cacheable |
| dc_addr | input | 28 | Data-port byte address (read and store) |
| dc_wdata | input | 36 | Store word: byte enables [35:32], data [31:0] |
| ic_rd | input | 1 | Instruction-port line read request, one-cycle strobe |
| ic_nc | input | 1 | Instruction-port read is non-cacheable |
| ic_addr | input | 28 | Instruction-port byte address |
| rd_data | output | 32 | Dword delivered on the current beat |
| waddr | output | 10 | Cache-RAM write address bits [11:2] |
| dc_wctrl | output | 3 | Data-port control: [2] first Dword, [1] write pulse, [0] non-cacheable |
| ic_wctrl | output | 3 | Instruction-port control, same layout |
| dc_done | output | 1 | Data-port fill complete |
| ic_done | output | 1 | Instruction-port fill complete |
| wr_en | output | 1 | Store can be accepted without merging |

## Verification
Two sequences are driven by hand because they can collide in a single cycle. The first is both ports strobing a read on the same edge. It is judged by checking that the four data-port beats and the four instruction-port beats run back to back with no idle cycle between them and in that order. The second is a read burst running while the data port keeps storing. Here the buffers must keep filling without draining, so wr_en must fall, a same-line store must still land, a foreign-line store must vanish, and wr_en must rise again one cycle after the burst ends. The contents are then read back non-cacheably and compared against a model the bench keeps from its own store history.

// File: rtl/lf_pkg.sv
// Shared constants and types for the line-fill memory emulator.
package lf_pkg;
    localparam int DW        = 32;               // Dword width
    localparam int BE_W      = DW / 8;           // byte enables per Dword
    localparam int BEATS     = 4;                // Dwords per cache line
    localparam int IDX_W     = $clog2(BEATS);    // Dword index width
    localparam int LINE_BITS = DW * BEATS;       // data bits in one line
    localparam int LINE_BE   = BE_W * BEATS;     // byte enables in one line
    localparam int CTL_W     = 3;                // write-control width

    // Which cache a burst belongs to.
    typedef enum logic {
        SRC_DATA = 1'b0,
        SRC_INSN = 1'b1
    } src_e;
endpackage

// File: rtl/lf_burst_seq.sv
// Burst sequencer: arbitrates the two read ports and steps through the
// Dwords of one line in critical-word-first interleaved order.
// Assumes each requester strobes once and waits for its done before asking
// again; a second strobe from a port that is still pending is ignored.
module lf_burst_seq
    import lf_pkg::*;
#(
    parameter int AW = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             d_req,
    input  logic [AW-1:0]    d_addr,
    input  logic             d_nc,
    input  logic             i_req,
    input  logic [AW-1:0]    i_addr,
    input  logic             i_nc,
    output logic             beat_vld,
    output src_e             beat_src,
    output logic [IDX_W-1:0] beat_idx,
    output logic             beat_first,
    output logic             beat_last,
    output logic             beat_nc,
    output logic [AW-1:0]    beat_addr
);
    logic             busy_q, nc_q;
    src_e             src_q;
    logic [IDX_W-1:0] start_q, cnt_q;
    logic [AW-1:0]    addr_q;
    logic             dp_q, ip_q, dpn_q, ipn_q;
    logic [AW-1:0]    dpa_q, ipa_q;

    logic             d_has, i_has, d_n, i_n, last, free, go, take_d, take_i;
    logic [AW-1:0]    d_a, i_a;

    // Merge fresh strobes with held requests and decide whether a burst starts.
    always_comb begin
        d_has  = dp_q | d_req;
        i_has  = ip_q | i_req;
        d_a    = dp_q ? dpa_q : d_addr;
        i_a    = ip_q ? ipa_q : i_addr;
        d_n    = dp_q ? dpn_q : d_nc;
        i_n    = ip_q ? ipn_q : i_nc;
        last   = busy_q & (nc_q | (cnt_q == IDX_W'(BEATS - 1)));
        free   = ~busy_q | last;
        go     = free & (d_has | i_has);
        take_d = go & d_has;
        take_i = go & ~d_has;
    end

    // Burst state: load on start, count beats, drop busy after the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            src_q   <= SRC_DATA;
            start_q <= '0;
            cnt_q   <= '0;
            nc_q    <= 1'b0;
            addr_q  <= '0;
        end else if (go) begin
            busy_q  <= 1'b1;
            src_q   <= d_has ? SRC_DATA : SRC_INSN;
            addr_q  <= d_has ? d_a : i_a;
            nc_q    <= d_has ? d_n : i_n;
            start_q <= d_has ? d_a[IDX_W+1:2] : i_a[IDX_W+1:2];
            cnt_q   <= '0;
        end else if (last) begin
            busy_q  <= 1'b0;
        end else if (busy_q) begin
            cnt_q   <= cnt_q + IDX_W'(1);
        end
    end

    // Hold a request that could not start at once (lost arbitration or busy).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dp_q <= 1'b0; dpn_q <= 1'b0; dpa_q <= '0;
            ip_q <= 1'b0; ipn_q <= 1'b0; ipa_q <= '0;
        end else begin
            if (take_d) dp_q <= 1'b0;
            else if (d_req && !dp_q) begin
                dp_q <= 1'b1; dpa_q <= d_addr; dpn_q <= d_nc;
            end
            if (take_i) ip_q <= 1'b0;
            else if (i_req && !ip_q) begin
                ip_q <= 1'b1; ipa_q <= i_addr; ipn_q <= i_nc;
            end
        end
    end

    assign beat_vld   = busy_q;
    assign beat_src   = src_q;
    assign beat_idx   = start_q ^ cnt_q;
    assign beat_first = (cnt_q == '0);
    assign beat_last  = last;
    assign beat_nc    = nc_q;
    assign beat_addr  = addr_q;

    a_r1_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !last) |=> (busy_q && cnt_q == $past(cnt_q) + IDX_W'(1)));
    a_r2_first_word: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (beat_first && beat_idx == $past(d_has ? d_a[IDX_W+1:2] : i_a[IDX_W+1:2])));
    a_r5_nc_single: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && nc_q && !go) |=> !busy_q);
    a_r6_data_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (free && d_has && i_has) |=> (busy_q && src_q == SRC_DATA));
    a_r6_insn_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (last && src_q == SRC_DATA && ip_q && !dp_q && !d_req)
        |=> (busy_q && src_q == SRC_INSN && beat_first));
endmodule

// File: rtl/lf_wbuf.sv
// Store buffers: a small FIFO of line-wide entries. A store to the line held
// in the newest entry merges into it; otherwise it takes a free entry. The
// oldest entry drains whole (with per-byte enables) in a cycle with no store
// and no read beat. NBUF must be a power of two.
module lf_wbuf
    import lf_pkg::*;
#(
    parameter int AW   = 28,
    parameter int NBUF = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [AW-3:0]        wa,
    input  logic [DW+BE_W-1:0]   wdata,
    input  logic                 hold,
    output logic                 wr_en,
    output logic                 drn_vld,
    output logic [AW-3-IDX_W:0]  drn_line,
    output logic [LINE_BITS-1:0] drn_data,
    output logic [LINE_BE-1:0]   drn_be
);
    localparam int LW = AW - 2 - IDX_W;
    localparam int PW = (NBUF > 1) ? $clog2(NBUF) : 1;
    localparam int CW = $clog2(NBUF + 1);

    logic [LW-1:0]        line_q [NBUF];
    logic [LINE_BITS-1:0] data_q [NBUF];
    logic [LINE_BE-1:0]   be_q   [NBUF];
    logic [PW-1:0]        hd_q;
    logic [CW-1:0]        cnt_q;

    logic [PW-1:0]    tail, wptr, tgt;
    logic [LW-1:0]    w_line;
    logic [IDX_W-1:0] w_dw;
    logic [BE_W-1:0]  w_be;
    logic [DW-1:0]    w_d;
    logic             merge, accept, drain;

    // Decode the incoming store and pick merge, allocate, drop or drain.
    always_comb begin
        w_line = wa[AW-3:IDX_W];
        w_dw   = wa[IDX_W-1:0];
        w_be   = wdata[DW+BE_W-1:DW];
        w_d    = wdata[DW-1:0];
        tail   = PW'(hd_q + PW'(cnt_q) - PW'(1));
        wptr   = PW'(hd_q + PW'(cnt_q));
        merge  = wr && (cnt_q != '0) && (line_q[tail] == w_line);
        accept = wr && (merge || cnt_q < CW'(NBUF));
        drain  = (cnt_q != '0) && !wr && !hold;
        tgt    = merge ? tail : wptr;
    end

    // Entry contents: new line on allocation, enabled bytes on every accept.
    always_ff @(posedge clk) begin
        if (accept) begin
            if (!merge) begin
                line_q[tgt] <= w_line;
                be_q[tgt]   <= '0;
            end
            for (int b = 0; b < BE_W; b++) begin
                if (w_be[b]) begin
                    data_q[tgt][int'(w_dw)*DW + b*8 +: 8] <= w_d[b*8 +: 8];
                    be_q[tgt][int'(w_dw)*BE_W + b]        <= 1'b1;
                end
            end
        end
    end

    // Occupancy and head pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hd_q  <= '0;
            cnt_q <= '0;
        end else if (accept && !merge) begin
            cnt_q <= cnt_q + CW'(1);
        end else if (drain) begin
            hd_q  <= hd_q + PW'(1);
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign wr_en    = (cnt_q < CW'(NBUF));
    assign drn_vld  = drain;
    assign drn_line = line_q[hd_q];
    assign drn_data = data_q[hd_q];
    assign drn_be   = be_q[hd_q];

    a_r8_no_drain_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !wr) |=> (cnt_q == $past(cnt_q)));
    a_r8_reopen: assert property (@(posedge clk) disable iff (!rst_n)
        (drain && !wr_en) |=> wr_en);
    a_r9_merge_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && merge) |=> (cnt_q == $past(cnt_q)));
    a_r9_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !wr_en && !merge) |=> (cnt_q == $past(cnt_q) && hd_q == $past(hd_q)));
endmodule

// File: rtl/lf_mem.sv
// Storage array: one asynchronous Dword read port for beats and one
// synchronous line-wide write port with per-byte enables for drains.
// Contents are not reset; unwritten words read as unknown.
module lf_mem
    import lf_pkg::*;
#(
    parameter int WORDS = 4096
) (
    input  logic                  clk,
    input  logic [$clog2(WORDS)-1:0] rd_idx,
    output logic [DW-1:0]         rd_word,
    input  logic                  we,
    input  logic [$clog2(WORDS)-IDX_W-1:0] wr_line,
    input  logic [LINE_BITS-1:0]  wr_data,
    input  logic [LINE_BE-1:0]    wr_be
);
    logic [DW-1:0] mem_q [WORDS];

    // Write the enabled bytes of a drained line.
    always_ff @(posedge clk) begin
        if (we) begin
            for (int dw = 0; dw < BEATS; dw++) begin
                for (int b = 0; b < BE_W; b++) begin
                    if (wr_be[dw*BE_W + b])
                        mem_q[{wr_line, IDX_W'(dw)}][b*8 +: 8] <= wr_data[dw*DW + b*8 +: 8];
                end
            end
        end
    end

    assign rd_word = mem_q[rd_idx];
endmodule

// File: rtl/lf_linefill_mem.sv
// Top of the line-fill memory emulator. Joins the burst sequencer, the store
// buffers and the storage array, decodes the implemented range and shapes the
// per-port control pulses. Single clock; read beats own the array port.
module lf_linefill_mem
    import lf_pkg::*;
#(
    parameter int AW        = 28,
    parameter int MEM_BYTES = 16384,
    parameter int NBUF      = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dc_rd,
    input  logic          dc_wr,
    input  logic          dc_nc,
    input  logic [AW-1:0] dc_addr,
    input  logic [35:0]   dc_wdata,
    input  logic          ic_rd,
    input  logic          ic_nc,
    input  logic [AW-1:0] ic_addr,
    output logic [31:0]   rd_data,
    output logic [9:0]    waddr,
    output logic [2:0]    dc_wctrl,
    output logic [2:0]    ic_wctrl,
    output logic          dc_done,
    output logic          ic_done,
    output logic          wr_en
);
    localparam int WORDS  = MEM_BYTES / BE_W;
    localparam int MEM_AW = $clog2(MEM_BYTES);
    localparam int WA     = MEM_AW - 2;
    localparam int LW     = AW - 2 - IDX_W;
    localparam int ML     = WA - IDX_W;
    localparam int WA_TOP = 11;

    logic             beat_vld, beat_first, beat_last, beat_nc;
    src_e             beat_src;
    logic [IDX_W-1:0] beat_idx;
    logic [AW-1:0]    beat_addr;
    logic             drn_vld;
    logic [LW-1:0]    drn_line;
    logic [LINE_BITS-1:0] drn_data;
    logic [LINE_BE-1:0]   drn_be;
    logic [DW-1:0]    mem_word;
    logic             rd_in, wr_in;
    logic [CTL_W-1:0] ctl;
    logic [3:0]       unused_bits;

    lf_burst_seq #(.AW(AW)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .d_req(dc_rd), .d_addr(dc_addr), .d_nc(dc_nc),
        .i_req(ic_rd), .i_addr(ic_addr), .i_nc(ic_nc),
        .beat_vld(beat_vld), .beat_src(beat_src), .beat_idx(beat_idx),
        .beat_first(beat_first), .beat_last(beat_last), .beat_nc(beat_nc),
        .beat_addr(beat_addr)
    );

    lf_wbuf #(.AW(AW), .NBUF(NBUF)) u_wbuf (
        .clk(clk), .rst_n(rst_n),
        .wr(dc_wr), .wa(dc_addr[AW-1:2]), .wdata(dc_wdata), .hold(beat_vld),
        .wr_en(wr_en), .drn_vld(drn_vld), .drn_line(drn_line),
        .drn_data(drn_data), .drn_be(drn_be)
    );

    lf_mem #(.WORDS(WORDS)) u_mem (
        .clk(clk),
        .rd_idx({beat_addr[MEM_AW-1:IDX_W+2], beat_idx}),
        .rd_word(mem_word),
        .we(drn_vld && wr_in),
        .wr_line(drn_line[ML-1:0]),
        .wr_data(drn_data),
        .wr_be(drn_be)
    );

    // Range decode, beat data and per-port control shaping.
    always_comb begin
        rd_in    = (beat_addr[AW-1:MEM_AW] == '0);
        wr_in    = (drn_line[LW-1:ML] == '0);
        rd_data  = (beat_vld && rd_in) ? mem_word : '0;
        waddr    = {beat_addr[WA_TOP:IDX_W+2], beat_idx};
        ctl      = {beat_first, 1'b1, beat_nc};
        dc_wctrl = (beat_vld && beat_src == SRC_DATA) ? ctl : '0;
        ic_wctrl = (beat_vld && beat_src == SRC_INSN) ? ctl : '0;
        dc_done  = beat_vld && beat_last && beat_src == SRC_DATA;
        ic_done  = beat_vld && beat_last && beat_src == SRC_INSN;
    end

    assign unused_bits = beat_addr[3:0];

    a_r6_one_port: assert property (@(posedge clk) disable iff (!rst_n)
        !((|dc_wctrl) && (|ic_wctrl)));
    a_r5_nc_done: assert property (@(posedge clk) disable iff (!rst_n)
        (dc_wctrl[0] |-> dc_done) and (ic_wctrl[0] |-> ic_done));
    a_r1_pulse_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        (dc_done |-> dc_wctrl[1]) and (ic_done |-> ic_wctrl[1]));
endmodule

// File: tb/sim_lf_linefill_mem.sv
// Bench for the line-fill memory emulator: a read-vector table walked by
// one loop, then directed tests for arbitration, stores and range.
module sim_lf_linefill_mem;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        dc_rd, dc_wr, dc_nc, ic_rd, ic_nc;
    logic [27:0] dc_addr, ic_addr;
    logic [35:0] dc_wdata;
    logic [31:0] rd_data;
    logic [9:0]  waddr;
    logic [2:0]  dc_wctrl, ic_wctrl;
    logic        dc_done, ic_done, wr_en;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] model [4096];

    always #10 clk = ~clk;

    lf_linefill_mem u0 (
        .clk(clk), .rst_n(rst_n),
        .dc_rd(dc_rd), .dc_wr(dc_wr), .dc_nc(dc_nc), .dc_addr(dc_addr),
        .dc_wdata(dc_wdata), .ic_rd(ic_rd), .ic_nc(ic_nc), .ic_addr(ic_addr),
        .rd_data(rd_data), .waddr(waddr), .dc_wctrl(dc_wctrl), .ic_wctrl(ic_wctrl),
        .dc_done(dc_done), .ic_done(ic_done), .wr_en(wr_en)
    );

    // Read vectors: [29] instruction port, [28] non-cacheable, [27:0] address.
    localparam logic [29:0] RD_VEC [8] = '{
        {1'b0, 1'b0, 28'h000_0000}, {1'b0, 1'b0, 28'h000_0014},
        {1'b1, 1'b0, 28'h000_0028}, {1'b1, 1'b0, 28'h000_003C},
        {1'b0, 1'b1, 28'h000_02A8}, {1'b1, 1'b1, 28'h000_0004},
        {1'b0, 1'b0, 28'h000_02AC}, {1'b1, 1'b0, 28'h000_02A4}
    };

    function automatic logic [31:0] pat(input int w);
        return 32'h5A00_0000 ^ (w * 32'h0101_0107);
    endfunction

    function automatic logic [31:0] exp_word(input logic [27:0] a, input logic [1:0] ix);
        if (a[27:14] != '0) return 32'h0;
        return model[{a[13:4], ix}];
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(input logic [27:0] a, input logic [31:0] d,
                            input logic [3:0] be, input bit upd);
        dc_wr = 1'b1; dc_addr = a; dc_wdata = {be, d};
        @(negedge clk);
        dc_wr = 1'b0;
        if (upd && a[27:14] == '0)
            for (int b = 0; b < 4; b++)
                if (be[b]) model[a[13:2]][b*8 +: 8] = d[b*8 +: 8];
    endtask

    task automatic fill_line(input logic [27:0] base);
        for (int k = 0; k < 4; k++)
            do_write(base + 28'(4*k), pat(int'(base[13:2]) + k), 4'hF, 1'b1);
        idle(3);
    endtask

    task automatic issue(input bit d, input bit i, input logic [27:0] da,
                         input logic [27:0] ia, input bit dn, input bit inc);
        dc_rd = d; dc_addr = da; dc_nc = dn;
        ic_rd = i; ic_addr = ia; ic_nc = inc;
        @(negedge clk);
        dc_rd = 1'b0; ic_rd = 1'b0;
    endtask

    // Checks every beat of one fill, starting with beat 0 visible now.
    task automatic run_beats(input bit is_i, input logic [27:0] a, input bit nc,
                             input string tag);
        int n;
        n = nc ? 1 : 4;
        for (int k = 0; k < n; k++) begin
            logic [1:0]  ix;
            logic [2:0]  wc;
            logic [49:0] e, act;
            ix  = a[3:2] ^ k[1:0];
            wc  = {k == 0, 1'b1, nc};
            e   = {exp_word(a, ix), a[11:4], ix, wc, 3'b000, k == n - 1, 1'b0};
            act = {rd_data, waddr, is_i ? ic_wctrl : dc_wctrl, is_i ? dc_wctrl : ic_wctrl,
                   is_i ? ic_done : dc_done, is_i ? dc_done : ic_done};
            chk(tag, 64'(act), 64'(e));
            @(negedge clk);
        end
    endtask

    task automatic chk_quiet(input string tag);
        chk(tag, 64'({dc_wctrl, ic_wctrl, dc_done, ic_done}), 64'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired act=hung exp=finished");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; dc_rd = 0; dc_wr = 0; dc_nc = 0; ic_rd = 0; ic_nc = 0;
        dc_addr = '0; ic_addr = '0; dc_wdata = '0;
        idle(3);
        rst_n = 1'b1;
        // R11: reset state
        chk("R11 reset state", 64'({dc_wctrl, ic_wctrl, dc_done, ic_done, wr_en, rd_data}),
            64'({3'b0, 3'b0, 1'b0, 1'b0, 1'b1, 32'h0}));

        fill_line(28'h000); fill_line(28'h010); fill_line(28'h020);
        fill_line(28'h030); fill_line(28'h2A0);

        // R1 R2 R3 R4 R5: vector table over start indices, ports and modes
        for (int v = 0; v < 8; v++) begin
            logic p, nc;
            logic [27:0] a;
            {p, nc, a} = RD_VEC[v];
            issue(!p, p, a, a, nc, nc);
            run_beats(p, a, nc, nc ? "R5 single beat" : "R1/R2/R3/R4 burst");
            chk_quiet("R1 quiet after fill");
        end

        // R6: simultaneous requests, data first then instruction with no gap
        issue(1'b1, 1'b1, 28'h018, 28'h024, 1'b0, 1'b0);
        run_beats(1'b0, 28'h018, 1'b0, "R6 data port first");
        run_beats(1'b1, 28'h024, 1'b0, "R6 instruction port next");
        chk_quiet("R6 quiet after both");

        // R7: partial byte enables (bytes 0 and 2)
        do_write(28'h014, 32'hFFFF_FFFF, 4'b0101, 1'b1);
        idle(3);
        chk("R7 expected word", 64'(model[5]), 64'((pat(5) & 32'hFF00_FF00) | 32'h00FF_00FF));
        issue(1'b1, 1'b0, 28'h014, 28'h0, 1'b1, 1'b0);
        run_beats(1'b0, 28'h014, 1'b1, "R7 byte enables");

        // R8 R9: stores during a burst fill both buffers
        dc_rd = 1'b1; dc_addr = 28'h000; dc_nc = 1'b0;
        @(negedge clk);
        dc_rd = 1'b0;
        do_write(28'h030, 32'h1111_2222, 4'hF, 1'b1);
        do_write(28'h040, 32'h3333_4444, 4'hF, 1'b1);
        chk("R8 wr_en low when full", 64'(wr_en), 64'h0);
        do_write(28'h044, 32'h5555_6666, 4'hF, 1'b1);
        chk("R9 wr_en low after merge", 64'(wr_en), 64'h0);
        do_write(28'h2A0, 32'h7777_8888, 4'hF, 1'b0);
        chk("R8 no drain during burst", 64'(wr_en), 64'h0);
        @(negedge clk);
        chk("R8 wr_en high after drain", 64'(wr_en), 64'h1);
        idle(3);
        issue(1'b1, 1'b0, 28'h030, 28'h0, 1'b1, 1'b0);
        run_beats(1'b0, 28'h030, 1'b1, "R8 buffered store");
        issue(1'b1, 1'b0, 28'h040, 28'h0, 1'b1, 1'b0);
        run_beats(1'b0, 28'h040, 1'b1, "R8 second buffer");
        issue(1'b1, 1'b0, 28'h044, 28'h0, 1'b1, 1'b0);
        run_beats(1'b0, 28'h044, 1'b1, "R9 merged store kept");
        issue(1'b1, 1'b0, 28'h2A0, 28'h0, 1'b1, 1'b0);
        run_beats(1'b0, 28'h2A0, 1'b1, "R9 foreign store dropped");

        // R10: out-of-range store and read
        do_write(28'h4000, 32'hDEAD_BEEF, 4'hF, 1'b1);
        idle(3);
        issue(1'b1, 1'b0, 28'h000, 28'h0, 1'b1, 1'b0);
        run_beats(1'b0, 28'h000, 1'b1, "R10 alias untouched");
        issue(1'b0, 1'b1, 28'h0, 28'h4008, 1'b0, 1'b0);
        run_beats(1'b1, 28'h4008, 1'b0, "R10 out of range reads zero");
        chk_quiet("R10 quiet after fill");

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule